// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures the rotation period of several fans. Each fan's tachometer
output is synchronised and edge-detected. While a revolution is in progress, the
block counts ticks of a slow gating clock. The fan is taken to give two tach
pulses per revolution, so one measurement runs from a rising edge to the second
rising edge after it. The edge that closes one measurement opens the next. The
measured count is 12 bits wide and saturates. Speed in RPM is 1,500,000 divided
by the count, with the default 25 kHz gate. A saturated count of 0xFFF means the
fan is too slow to measure, below about 366 RPM.

Software reaches the block through a byte-wide index/data port. Each channel
exposes three registers:

- A read-only period count, occupying two bytes.
- A low-speed limit, occupying two bytes.
- A control byte whose bit 7 switches that channel's monitoring off.

Reading the high byte of the count captures the low byte at the same moment, so
the two bytes always come from the same measurement. A limit takes effect only
when its low byte is written, and that write commits both bytes together. A
per-channel alarm output goes high when the count is above the limit. A limit of
0xFFF turns the alarm off for that channel.

Each channel runs a small state machine:

- TS_OFF: the channel is disabled.
- TS_ARM: the channel waits for a first rising edge.
- TS_HALF: the first pulse period is being counted.
- TS_FULL: the second pulse period is being counted.

It moves through these transitions:

- From any state, clearing enable goes to TS_OFF.
- TS_OFF goes to TS_ARM once enable is set.
- TS_ARM goes to TS_HALF on a rising edge.
- TS_HALF goes to TS_FULL on a rising edge.
- TS_FULL goes to TS_HALF on a rising edge, which publishes the count.
- TS_ARM, TS_HALF and TS_FULL all go to TS_ARM when the counter saturates, which publishes 0xFFF.

Top module: `fan_tach_monitor`

## Requirements
- R1: After reset every count reads 0x0000, every limit reads 0x0FFF, every control byte reads 0x00, and all alarms are low.
- R2: In steady rotation with a tach pulse period of T gate ticks, the published count equals 2*T. It is measured from one rising edge to the second rising edge after it, and successive measurements follow back to back.
- R3: If 4095 gate ticks pass without the measurement completing, the published count becomes 0xFFF. This covers a fan with no pulses and a period of 2048 ticks or more.
- R4: For channel n, the count high byte is at index 0x20+2n and the low byte at 0x21+2n. The limit high byte is at 0x28+2n and the low byte at 0x29+2n. The high byte carries bits 11:8 in its bits 3:0, and its bits 7:4 read as zero.
- R5: Reading the count high byte captures the low byte at the same time. A later low-byte read returns the captured byte even if the count has changed since.
- R6: Writing the limit high byte alone leaves the readable limit unchanged. Writing the low byte commits the stored high bits and the new low byte together.
- R7: The alarm is high when the count is strictly greater than the limit, and that includes a saturated count. A count equal to the limit gives no alarm.
- R8: A limit of 0xFFF never raises the alarm, even when the count is saturated.
- R9: Bit 7 of the control byte at 0x60+16n disables channel n. A disabled channel holds its alarm low and freezes its count. Clearing the bit restarts measurement, and the other control bits have no effect and read as zero.
- R10: The count stays 0 until the first measurement completes, so a zero limit gives no alarm before then.
- R11: Channels measure independently, and each reports its own period.
- R12: Read data appears on the cycle after the read strobe. Unmapped indices read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tach_in | input | NFAN | Raw tachometer inputs, one per fan |
| reg_addr | input | 8 | Register index |
| reg_wdata | input | 8 | Write data byte |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| fan_alarm | output | NFAN | Per-fan low-speed alarm |

## Verification
The bench first sweeps one channel's pulse period over every value from 2 to 40 gate ticks. This separates an exact two-period count from an off-by-one at either end of the window. Periods of 2047 and 2048 ticks, and a stopped fan, separate the largest valid count (0xFFE) from saturation. A period change between a high-byte read and a low-byte read shows whether the low byte was truly captured. Limits on either side of and equal to a known count check the strict comparison, the 0xFFF disable, and the disable bit against a count that keeps changing.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

    typedef enum logic [1:0] {
        TS_OFF  = 2'd0,
        TS_ARM  = 2'd1,
        TS_HALF = 2'd2,
        TS_FULL = 2'd3
    } tach_state_e;

    // Register index map: channel n sits at BASE + stride*n
    localparam logic [7:0] CNT_BASE    = 8'h20;
    localparam logic [7:0] LIM_BASE    = 8'h28;
    localparam logic [7:0] CTL_BASE    = 8'h60;
    localparam int         PAIR_STRIDE = 2;
    localparam int         CTL_STRIDE  = 16;

endpackage

// File: rtl/gate_tick.sv
module gate_tick #(
    parameter int DIV = 4000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] div_q;

    assign tick = (div_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/tach_edge_sync.sv
module tach_edge_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] tach_in,
    output logic [N-1:0] rise
);
    logic [N-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= tach_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/fan_period_fsm.sv
module fan_period_fsm
    import fan_tach_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic             rise,
    output logic [CNT_W-1:0] count_q
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_PEAK = CNT_MAX - 1'b1;

    tach_state_e      state_q, state_d;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_inc;
    logic             near_full;

    assign run_inc   = run_q + {{(CNT_W-1){1'b0}}, tick};
    assign near_full = tick && (run_q == CNT_PEAK);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_OFF:  if (enable) state_d = TS_ARM;
            TS_ARM:  if (rise) state_d = TS_HALF;
            TS_HALF: begin
                if (near_full)  state_d = TS_ARM;
                else if (rise)  state_d = TS_FULL;
            end
            TS_FULL: begin
                if (rise)           state_d = TS_HALF;
                else if (near_full) state_d = TS_ARM;
            end
        endcase
        if (!enable) state_d = TS_OFF;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TS_OFF;
        else        state_q <= state_d;
    end

    // Running counter and published count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= '0;
            count_q <= '0;
        end else if (!enable) begin
            run_q <= '0;
        end else begin
            unique case (state_q)
                TS_OFF: run_q <= '0;
                TS_ARM: begin
                    if (rise) begin
                        run_q <= '0;
                    end else if (near_full) begin
                        count_q <= CNT_MAX;
                        run_q   <= '0;
                    end else begin
                        run_q <= run_inc;
                    end
                end
                TS_HALF: begin
                    if (near_full) begin
                        count_q <= CNT_MAX;
                        run_q   <= '0;
                    end else begin
                        run_q <= run_inc;
                    end
                end
                TS_FULL: begin
                    if (rise) begin
                        count_q <= run_inc;
                        run_q   <= '0;
                    end else if (near_full) begin
                        count_q <= CNT_MAX;
                        run_q   <= '0;
                    end else begin
                        run_q <= run_inc;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/fan_regs.sv
module fan_regs
    import fan_tach_pkg::*;
#(
    parameter int NFAN  = 3,
    parameter int CNT_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            reg_addr,
    input  logic [7:0]            reg_wdata,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [NFAN*CNT_W-1:0] cnt_flat,
    output logic [NFAN*CNT_W-1:0] lim_flat,
    output logic [NFAN-1:0]       fan_off,
    output logic [7:0]            reg_rdata
);
    localparam int HI_W  = CNT_W - 8;
    localparam int PAD_W = 8 - HI_W;

    logic [7:0] ch_word [NFAN];
    logic [7:0] rd_mux;

    for (genvar n = 0; n < NFAN; n++) begin : g_ch
        localparam logic [7:0] A_CH = 8'(CNT_BASE + PAIR_STRIDE * n);
        localparam logic [7:0] A_CL = 8'(A_CH + 1);
        localparam logic [7:0] A_LH = 8'(LIM_BASE + PAIR_STRIDE * n);
        localparam logic [7:0] A_LL = 8'(A_LH + 1);
        localparam logic [7:0] A_CT = 8'(CTL_BASE + CTL_STRIDE * n);

        logic [CNT_W-1:0] cnt_n;
        logic [CNT_W-1:0] lim_q;
        logic [HI_W-1:0]  lim_hi_q;
        logic [7:0]       lo_latch_q;
        logic             off_q;

        assign cnt_n = cnt_flat[n*CNT_W +: CNT_W];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lim_q      <= '1;
                lim_hi_q   <= '0;
                lo_latch_q <= '0;
                off_q      <= 1'b0;
            end else begin
                if (reg_wr && reg_addr == A_LH) lim_hi_q <= reg_wdata[HI_W-1:0];
                if (reg_wr && reg_addr == A_LL) lim_q <= {lim_hi_q, reg_wdata};
                if (reg_wr && reg_addr == A_CT) off_q <= reg_wdata[7];
                if (reg_rd && reg_addr == A_CH) lo_latch_q <= cnt_n[7:0];
            end
        end

        assign ch_word[n] = (reg_addr == A_CH) ? {{PAD_W{1'b0}}, cnt_n[CNT_W-1:8]} :
                            (reg_addr == A_CL) ? lo_latch_q :
                            (reg_addr == A_LH) ? {{PAD_W{1'b0}}, lim_q[CNT_W-1:8]} :
                            (reg_addr == A_LL) ? lim_q[7:0] :
                            (reg_addr == A_CT) ? {off_q, 7'b0} : 8'h00;

        assign lim_flat[n*CNT_W +: CNT_W] = lim_q;
        assign fan_off[n] = off_q;
    end

    always_comb begin
        rd_mux = 8'h00;
        for (int n = 0; n < NFAN; n++) rd_mux = rd_mux | ch_word[n];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= 8'h00;
        else if (reg_rd) reg_rdata <= rd_mux;
    end
endmodule

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor
    import fan_tach_pkg::*;
#(
    parameter int NFAN     = 3,
    parameter int CNT_W    = 12,
    parameter int GATE_DIV = 4000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NFAN-1:0] tach_in,
    input  logic [7:0]      reg_addr,
    input  logic [7:0]      reg_wdata,
    input  logic            reg_wr,
    input  logic            reg_rd,
    output logic [7:0]      reg_rdata,
    output logic [NFAN-1:0] fan_alarm
);
    localparam logic [CNT_W-1:0] LIM_QUIET = '1;

    logic                  gate_pulse;
    logic [NFAN-1:0]       tach_rise;
    logic [NFAN-1:0]       fan_off;
    logic [NFAN*CNT_W-1:0] cnt_flat;
    logic [NFAN*CNT_W-1:0] lim_flat;

    gate_tick #(.DIV(GATE_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (gate_pulse)
    );

    tach_edge_sync #(.N(NFAN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .tach_in (tach_in),
        .rise    (tach_rise)
    );

    for (genvar n = 0; n < NFAN; n++) begin : g_fan
        logic [CNT_W-1:0] cnt_n, lim_n;

        fan_period_fsm #(.CNT_W(CNT_W)) u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .enable  (~fan_off[n]),
            .tick    (gate_pulse),
            .rise    (tach_rise[n]),
            .count_q (cnt_flat[n*CNT_W +: CNT_W])
        );

        assign cnt_n = cnt_flat[n*CNT_W +: CNT_W];
        assign lim_n = lim_flat[n*CNT_W +: CNT_W];
        // A saturated count exceeds every limit except the quiet value
        assign fan_alarm[n] = ~fan_off[n] && (lim_n != LIM_QUIET) && (cnt_n > lim_n);
    end

    fan_regs #(.NFAN(NFAN), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .cnt_flat  (cnt_flat),
        .lim_flat  (lim_flat),
        .fan_off   (fan_off),
        .reg_rdata (reg_rdata)
    );
endmodule

// File: rtl/fan_tach_monitor_checker.sv
module fan_tach_monitor_checker #(
    parameter int NFAN  = 3,
    parameter int CNT_W = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [7:0]            reg_addr,
    input logic                  reg_rd,
    input logic [7:0]            reg_rdata,
    input logic [NFAN-1:0]       fan_alarm,
    input logic [NFAN-1:0]       fan_off,
    input logic [NFAN*CNT_W-1:0] cnt_flat,
    input logic [NFAN*CNT_W-1:0] lim_flat
);
    localparam int HI_W = CNT_W - 8;
    localparam logic [CNT_W-1:0] QUIET = '1;

    assert_hi_nibble_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr[7:3] == 5'b00100 && !reg_addr[0]) |=> (reg_rdata[7:HI_W] == '0));

    assert_low_captured_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 8'h20) ##1 (reg_rd && reg_addr == 8'h21)
        |=> (reg_rdata == $past(cnt_flat[7:0], 2)));

    assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 8'h30) |=> (reg_rdata == 8'h00));

    for (genvar n = 0; n < NFAN; n++) begin : g_chk
        assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
            fan_off[n] |-> !fan_alarm[n]);

        assert_off_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (fan_off[n] && $past(fan_off[n])) |-> $stable(cnt_flat[n*CNT_W +: CNT_W]));

        assert_quiet_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (lim_flat[n*CNT_W +: CNT_W] == QUIET) |-> !fan_alarm[n]);

        assert_alarm_above_R7: assert property (@(posedge clk) disable iff (!rst_n)
            fan_alarm[n] |-> (cnt_flat[n*CNT_W +: CNT_W] > lim_flat[n*CNT_W +: CNT_W]));
    end
endmodule

bind fan_tach_monitor fan_tach_monitor_checker #(.NFAN(NFAN), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .fan_alarm (fan_alarm),
    .fan_off   (fan_off),
    .cnt_flat  (cnt_flat),
    .lim_flat  (lim_flat)
);

// File: tb/fan_tach_monitor_bench.sv
module fan_tach_monitor_bench;
    localparam int NF  = 3;
    localparam int CW  = 12;
    localparam int DIV = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NF-1:0] tach = '0;
    logic [7:0]    addr = 8'h00;
    logic [7:0]    wdata = 8'h00;
    logic          wr = 1'b0;
    logic          rd = 1'b0;
    logic [7:0]    rdata;
    logic [NF-1:0] alarm;

    int tper [NF];
    int phase [NF];
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    fan_tach_monitor #(.NFAN(NF), .CNT_W(CW), .GATE_DIV(DIV)) u_fan_tach_monitor (
        .clk       (clk),
        .rst_n     (rst_n),
        .tach_in   (tach),
        .reg_addr  (addr),
        .reg_wdata (wdata),
        .reg_wr    (wr),
        .reg_rd    (rd),
        .reg_rdata (rdata),
        .fan_alarm (alarm)
    );

    always #5 clk = ~clk;

    // Tach generator: period tper[c] gate ticks, rising edges exactly tper*DIV cycles apart
    initial begin
        for (int c = 0; c < NF; c++) begin
            tper[c]  = 0;
            phase[c] = 0;
        end
    end

    always @(negedge clk) begin
        for (int c = 0; c < NF; c++) begin
            if (tper[c] == 0) begin
                tach[c]  = 1'b0;
                phase[c] = 0;
            end else begin
                if (phase[c] == 0) tach[c] = 1'b1;
                if (phase[c] == tper[c] * DIV / 2) tach[c] = 1'b0;
                if (phase[c] + 1 >= tper[c] * DIV) phase[c] = 0;
                else phase[c] = phase[c] + 1;
            end
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle(input int old_t, input int new_t);
        wait_cyc((old_t + 3 * new_t) * DIV + 20);
    endtask

    task automatic rd8(input logic [7:0] a, output logic [7:0] v);
        addr = a;
        rd   = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        v  = rdata;
    endtask

    task automatic rd16(input logic [7:0] a, output int v);
        logic [7:0] hi, lo;
        rd8(a, hi);
        rd8(8'(a + 1), lo);
        v = {16'h0, hi, lo};
    endtask

    task automatic wr8(input logic [7:0] a, input logic [7:0] d);
        addr  = a;
        wdata = d;
        wr    = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int v;
        logic [7:0] b;
        int prev;

        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1: reset state
        for (int c = 0; c < NF; c++) begin
            rd16(8'(8'h20 + 2 * c), v); check("R1 count reset", v, 0);
            rd16(8'(8'h28 + 2 * c), v); check("R1 limit reset", v, 16'h0FFF);
            rd8(8'(8'h60 + 16 * c), b); check("R1 ctrl reset", int'(b), 0);
        end
        check("R1 alarms reset", int'(alarm), 0);

        // R10: zero limit, no measurement yet
        wr8(8'h28, 8'h00);
        wr8(8'h29, 8'h00);
        wait_cyc(100);
        rd16(8'h20, v); check("R10 count before first measurement", v, 0);
        check("R10 no alarm with zero count", int'(alarm[0]), 0);

        // R3: no pulses at all -> saturation
        wait_cyc(4100 * DIV);
        for (int c = 0; c < NF; c++) begin
            rd16(8'(8'h20 + 2 * c), v); check("R3 stopped fan saturates", v, 16'h0FFF);
        end
        check("R7 saturated count above zero limit", int'(alarm[0]), 1);
        check("R8 saturated count, quiet limit ch1", int'(alarm[1]), 0);
        check("R8 saturated count, quiet limit ch2", int'(alarm[2]), 0);
        wr8(8'h28, 8'h0F);
        wr8(8'h29, 8'hFF);

        // R2 sweep on channel 0; R11 with other channels at fixed periods
        tper[1] = 37;
        tper[2] = 100;
        tper[0] = 2;
        settle(0, 100);
        prev = 2;
        for (int t = 2; t <= 40; t++) begin
            tper[0] = t;
            settle(prev, t);
            prev = t;
            rd16(8'h20, v); check("R2 sweep count = 2*T", v, 2 * t);
        end
        rd16(8'h22, v); check("R11 channel 1 independent", v, 74);
        rd16(8'h24, v); check("R11 channel 2 independent", v, 200);

        // R5: capture on high read survives a count change
        tper[0] = 37;
        settle(40, 37);
        rd8(8'h20, b); check("R4 count high byte", int'(b), 8'h00);
        tper[0] = 100;
        settle(37, 100);
        rd8(8'h21, b); check("R5 low byte from capture", int'(b), 8'h4A);
        rd16(8'h20, v); check("R2 fresh count after capture", v, 200);

        // R6 / R7 on channel 1 (count 74)
        wr8(8'h2A, 8'h00);
        rd16(8'h2A, v); check("R6 high write alone not visible", v, 16'h0FFF);
        wr8(8'h2B, 8'h50);
        rd16(8'h2A, v); check("R6 commit on low write", v, 16'h0050);
        check("R7 count below limit", int'(alarm[1]), 0);
        tper[1] = 40;
        settle(37, 40);
        check("R7 count equal to limit", int'(alarm[1]), 0);
        tper[1] = 41;
        settle(40, 41);
        check("R7 count above limit", int'(alarm[1]), 1);
        wr8(8'h2C, 8'hA3);
        wr8(8'h2D, 8'h11);
        rd16(8'h2C, v); check("R4 limit upper bits read zero", v, 16'h0311);
        check("R7 ch2 below limit", int'(alarm[2]), 0);
        wr8(8'h2C, 8'h0F);
        wr8(8'h2D, 8'hFF);

        // R9: disable channel 1
        wr8(8'h70, 8'h7F);
        rd8(8'h70, b); check("R9 low control bits ignored", int'(b), 0);
        check("R9 alarm kept without bit 7", int'(alarm[1]), 1);
        wr8(8'h70, 8'h80);
        check("R9 disabled alarm low", int'(alarm[1]), 0);
        rd8(8'h70, b); check("R9 control readback", int'(b), 8'h80);
        tper[1] = 20;
        settle(41, 20);
        rd16(8'h22, v); check("R9 count frozen while disabled", v, 82);
        check("R9 alarm still low", int'(alarm[1]), 0);
        wr8(8'h70, 8'h00);
        settle(20, 20);
        rd16(8'h22, v); check("R9 measurement resumes", v, 40);

        // R8 / R7 with saturated count on channel 2
        tper[2] = 0;
        wait_cyc(4200 * DIV);
        rd16(8'h24, v); check("R3 pulses stop -> saturate", v, 16'h0FFF);
        check("R8 quiet limit with saturation", int'(alarm[2]), 0);
        wr8(8'h2C, 8'h0F);
        wr8(8'h2D, 8'hFE);
        check("R7 saturation above 0xFFE", int'(alarm[2]), 1);

        // R12
        rd8(8'h30, b); check("R12 unmapped index", int'(b), 0);
        rd8(8'h26, b); check("R12 absent channel index", int'(b), 0);

        // R2/R3 boundary
        tper[0] = 2047;
        settle(100, 2047);
        rd16(8'h20, v); check("R2 largest count", v, 16'h0FFE);
        tper[0] = 2048;
        settle(2047, 2048);
        rd16(8'h20, v); check("R3 period 2048 saturates", v, 16'h0FFF);

        finish_run();
    end
endmodule